// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine with Source Rewind

This block is one DMA channel. Each transfer reads one item from a source address and then writes that item to a fixed destination address. The item is 1, 2 or 4 bytes. Software sets up the channel through a small register write port: source start address, destination address, transfer count and a control word. It then starts the channel by writing the control word with its enable bit set. The engine issues bus cycles until the count runs out. It then raises a done flag and goes quiet.

In rewind mode the channel returns the source address to its programmed start after every group of four transfers. A fixed buffer of four items can then be replayed again and again into one destination, such as a data port. A two-bit group counter keeps track of the position within the group. That counter is cleared by several events: the global enable going low, the channel enable being low, the done flag setting, NMI, a standby request, a channel start and reset. None of these events clears the address or count registers. So if the counter is cleared in the middle of a group, the next rewind happens four transfers after the clear, wherever the source address then stands. Software is expected to reprogram the channel after such an interruption. When rewind is on, software should program a count that is a multiple of four.

Top module: `dma_reload_chan`

## Requirements
- R1: Each transfer is a read cycle (bus_we=0) at the working source address, then a write cycle (bus_we=1) at the destination address. The write drives the data captured from the read. The destination address changes only when software writes it.
- R2: A bus request is held with unchanged address, direction and write data until the cycle in which bus_ack is high. A read is acknowledged, and then the write follows.
- R3: When a transfer completes without a rewind, the working source address advances by 1, 2 or 4. The step depends on the size field, control bits [3:2] = 0, 1 or 2, which also appears on bus_size.
- R4: With the rewind bit set (control bit 1), the fourth completion of every group loads the working source address from the programmed start address. The fifth read of a run is therefore at the start address.
- R5: The count register decrements by one per completed transfer, with or without rewind. The completion that brings it from 1 to 0 sets done_flag. While done_flag is high, no bus cycle is issued.
- R6: A new transfer starts only when all of these hold: glb_en is high, the channel enable (control bit 0) is high, done_flag is low, nmi is low and the count is non-zero. A transfer already in progress runs to its write acknowledge.
- R7: The group counter is cleared by glb_en low, channel enable low, nmi, standby, done_flag setting, channel start and reset. The source, destination and count registers keep their values. After a clear, the next rewind comes on the fourth completion counted from the clear.
- R8: A write to the control word with bit 0 set clears done_flag and loads the working source address from the start address. Writing only the count leaves done_flag set and the channel idle.
- R9: Register select values on cfg_sel are 0 for the source start address, 1 for destination, 2 for count (low bits) and 3 for control. After reset, done_flag and bus_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| standby | input | 1 | Standby request, clears the group counter |
| glb_en | input | 1 | Global DMA enable |
| nmi | input | 1 | Non-maskable interrupt, stalls the channel and clears the group counter |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | AW | Register write data |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 for write cycle, 0 for read cycle |
| bus_addr | output | AW | Bus byte address |
| bus_size | output | 2 | Item size code, 0/1/2 for 1/2/4 bytes |
| bus_wdata | output | DW | Write data |
| bus_ack | input | 1 | Cycle acknowledge |
| bus_rdata | input | DW | Read data, valid with bus_ack on a read |
| done_flag | output | 1 | Transfer-end flag |

## Verification
Two functions can fall on the same clock edge: a transfer completion and a clear of the group counter. The completion may be a rewind completion, and the clear may come from NMI, standby, loss of global enable or the count reaching zero. The bench provokes this by raising nmi, standby or dropping glb_en right after the second, first or third completion of a group. It also ends runs on a fourth completion, so that done_flag and the rewind land together. A behavioural model is updated at every clock and expects the clear to win over the group increment while the address still steps. The bench judges the result by the read address sequence it logs and by done_flag on every cycle.

// File: rtl/dma_reload_pkg.sv
// Package: shared size codes, bus phases and register selects for the
// rewinding DMA channel. Assumes size code 3 is never programmed (treated
// as a 4-byte item).
package dma_reload_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } xfer_size_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } bus_phase_e;

    localparam logic [1:0] SEL_SRC  = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    // Byte step for one item of the given size code.
    function automatic logic [2:0] size_step(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_group_ctr.sv
// Module: modulo-GRP_LEN position counter inside a rewind group.
// Advances on each completed transfer and flags the last slot of a group.
// Assumes clr has priority over adv; reset is synchronous, active low.
module dma_group_ctr #(
    parameter int GRP_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic wrap
);
    localparam int GW = (GRP_LEN > 1) ? $clog2(GRP_LEN) : 1;
    localparam logic [GW-1:0] LAST = GW'(GRP_LEN - 1);

    logic [GW-1:0] grp;

    assign wrap = (grp == LAST);

    // Count completions, wrapping at the group end; any clear source wins.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            grp <= '0;
        end else if (adv) begin
            grp <= wrap ? '0 : grp + GW'(1);
        end
    end

    // R7: a clear event leaves the counter at the group start.
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (grp == '0));

endmodule

// File: rtl/dma_addr_unit.sv
// Module: source start (shadow), working source and destination addresses.
// Working source reloads from the shadow on channel start and on a rewind,
// otherwise steps by the item size per completed transfer.
// Assumes software does not rewrite addresses while a transfer is in flight.
module dma_addr_unit #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shadow_we,
    input  logic          dst_we,
    input  logic [AW-1:0] wdata,
    input  logic          load_src,
    input  logic          cmpl,
    input  logic          reload_now,
    input  logic [1:0]    size,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst
);
    import dma_reload_pkg::*;

    logic [AW-1:0] shadow;

    // Hold the programmed source start address.
    always_ff @(posedge clk) begin
        if (!rst_n)         shadow <= '0;
        else if (shadow_we) shadow <= wdata;
    end

    // Hold the destination address; no hardware update.
    always_ff @(posedge clk) begin
        if (!rst_n)      dst <= '0;
        else if (dst_we) dst <= wdata;
    end

    // Working source: reload on start or rewind, step on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src <= '0;
        end else if (load_src || reload_now) begin
            src <= shadow;
        end else if (cmpl) begin
            src <= src + AW'(size_step(size));
        end
    end

    // R4: a rewind completion returns the source to the start address.
    a_r4_rewind_to_start: assert property (@(posedge clk) disable iff (!rst_n)
        reload_now |=> (src == $past(shadow)));

    // R3: an ordinary completion steps the source by the item size.
    a_r3_src_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl && !reload_now && !load_src) |=>
            (src == $past(src) + AW'(size_step($past(size)))));

    // R1: destination moves only on a software write.
    a_r1_dst_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        !dst_we |=> $stable(dst));

endmodule

// File: rtl/dma_bus_seq.sv
// Module: bus cycle sequencer. One read at src, then one write at dst with
// the captured data; each cycle holds its request until ack.
// Assumes go is only sampled while idle; cmpl pulses on the write ack.
module dma_bus_seq #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          cmpl
);
    import dma_reload_pkg::*;

    bus_phase_e    phase;
    logic [DW-1:0] hold;

    // Step through idle, read and write phases on the handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE:  if (go)      phase <= PH_READ;
                PH_READ:  if (bus_ack) phase <= PH_WRITE;
                PH_WRITE: if (bus_ack) phase <= PH_IDLE;
                default:               phase <= PH_IDLE;
            endcase
        end
    end

    // Capture read data at the read acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                             hold <= '0;
        else if (phase == PH_READ && bus_ack)   hold <= bus_rdata;
    end

    // Drive the bus from the current phase.
    always_comb begin
        bus_req   = (phase != PH_IDLE);
        bus_we    = (phase == PH_WRITE);
        bus_addr  = (phase == PH_WRITE) ? dst : src;
        bus_wdata = hold;
        cmpl      = (phase == PH_WRITE) && bus_ack;
    end

    // R2: an unacknowledged request is held unchanged.
    a_r2_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=>
            (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

    // R1: an acknowledged read is followed by the write cycle.
    a_r1_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_ack) |=> (bus_req && bus_we));

endmodule

// File: rtl/dma_reload_chan.sv
// Module: top of the single DMA channel with four-transfer source rewind.
// Holds the count and control registers and the done flag, gates the
// start of each transfer and gathers the group-counter clear sources.
// Assumes configuration writes are made while the channel is idle and that
// CW <= AW.
module dma_reload_chan #(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int CW      = 16,
    parameter int GRP_LEN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby,
    input  logic          glb_en,
    input  logic          nmi,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata,
    output logic          done_flag
);
    import dma_reload_pkg::*;

    logic [CW-1:0] cnt;
    logic          ch_en;
    logic          rew_en;
    logic [1:0]    size;
    logic          ctrl_wr, cnt_wr, start;
    logic          go, cmpl, last, wrap, reload_now, grp_clr;
    logic [AW-1:0] src, dst;

    assign ctrl_wr    = cfg_we && (cfg_sel == SEL_CTRL);
    assign cnt_wr     = cfg_we && (cfg_sel == SEL_CNT);
    assign start      = ctrl_wr && cfg_wdata[0];
    assign last       = cmpl && (cnt == CW'(1));
    assign go         = glb_en && ch_en && !done_flag && !nmi && (cnt != '0);
    assign reload_now = cmpl && rew_en && wrap;
    assign grp_clr    = !glb_en || !ch_en || nmi || standby || last || start;
    assign bus_size   = size;

    // Control word: channel enable, rewind enable, item size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_en  <= 1'b0;
            rew_en <= 1'b0;
            size   <= SZ_BYTE;
        end else if (ctrl_wr) begin
            ch_en  <= cfg_wdata[0];
            rew_en <= cfg_wdata[1];
            size   <= cfg_wdata[3:2];
        end
    end

    // Transfer count: loaded by software, one down per completion.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (cnt_wr) cnt <= cfg_wdata[CW-1:0];
        else if (cmpl)   cnt <= cnt - CW'(1);
    end

    // Done flag: set on the last completion, cleared by a channel start.
    always_ff @(posedge clk) begin
        if (!rst_n)     done_flag <= 1'b0;
        else if (start) done_flag <= 1'b0;
        else if (last)  done_flag <= 1'b1;
    end

    dma_group_ctr #(.GRP_LEN(GRP_LEN)) u_grp (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (grp_clr),
        .adv   (cmpl),
        .wrap  (wrap)
    );

    dma_addr_unit #(.AW(AW)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .shadow_we  (cfg_we && (cfg_sel == SEL_SRC)),
        .dst_we     (cfg_we && (cfg_sel == SEL_DST)),
        .wdata      (cfg_wdata),
        .load_src   (start),
        .cmpl       (cmpl),
        .reload_now (reload_now),
        .size       (size),
        .src        (src),
        .dst        (dst)
    );

    dma_bus_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .src       (src),
        .dst       (dst),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cmpl      (cmpl)
    );

    // R5: no bus activity while the done flag is up.
    a_r5_quiet_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        done_flag |-> !bus_req);

    // R5: the done flag rises only with the count exhausted.
    a_r5_end_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> (cnt == '0));

    // R6: an idle channel stays idle while NMI is high.
    a_r6_nmi_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req && nmi) |=> !bus_req);

endmodule

// File: tb/dma_reload_chan_test.sv
module dma_reload_chan_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          standby = 1'b0, glb_en = 1'b0, nmi = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          bus_req, bus_we, done_flag;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_size;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic          bus_ack = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    // behavioural model of the channel
    logic [31:0] m_shadow = 0, m_src = 0, m_dst = 0, m_rd = 0;
    int          m_cnt = 0, m_grp = 0, m_size = 0;
    bit          m_te = 0, m_ch = 0, m_rel = 0;
    int          n_done = 0;
    int          wait_cnt = 0;
    bit          hold_prev = 0;
    logic [31:0] prev_addr = 0;
    logic        prev_we = 0;
    logic [31:0] rd_log[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mem_f(input logic [31:0] a);
        return a ^ 32'hC3C3_0000 ^ {a[15:0], 16'h0};
    endfunction

    assign bus_rdata = mem_f(bus_addr);

    dma_reload_chan uut (
        .clk(clk), .rst_n(rst_n), .standby(standby), .glb_en(glb_en), .nmi(nmi),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .done_flag(done_flag)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // Bus responder and model, predicting the next rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(done_flag == m_te, "R5 done_flag", 32'(done_flag), 32'(m_te));
            if (m_te) chk(!bus_req, "R5 quiet after end", 32'(bus_req), 0);
            if (bus_ack) begin
                bus_ack = 1'b0;
                hold_prev = 0;
            end else if (bus_req) begin
                if (hold_prev)
                    chk(bus_addr == prev_addr && bus_we == prev_we,
                        "R2 request held", bus_addr, prev_addr);
                if (wait_cnt > 0) begin
                    wait_cnt--;
                    hold_prev = 1;
                    prev_addr = bus_addr;
                    prev_we   = bus_we;
                end else begin
                    bus_ack = 1'b1;
                    hold_prev = 0;
                    wait_cnt = $urandom_range(0, 2);
                    if (!bus_we) begin
                        rd_log.push_back(bus_addr);
                        chk(bus_addr == m_src, "R1 read at source", bus_addr, m_src);
                        chk(32'(bus_size) == 32'(m_size), "R3 size code", 32'(bus_size), 32'(m_size));
                        m_rd = mem_f(m_src);
                    end else begin
                        chk(bus_addr == m_dst, "R1 write at destination", bus_addr, m_dst);
                        chk(bus_wdata == m_rd, "R1 write data", bus_wdata, m_rd);
                        m_cnt--;
                        if (m_rel && m_grp == 3) begin
                            m_src = m_shadow;
                            m_grp = 0;
                        end else begin
                            m_src = m_src + ((m_size == 0) ? 1 : (m_size == 1) ? 2 : 4);
                            m_grp = (m_grp + 1) % 4;
                        end
                        if (m_cnt == 0) begin
                            m_te = 1;
                            m_grp = 0;
                        end
                        n_done++;
                    end
                end
            end
            if (!glb_en || nmi || standby || !m_ch) m_grp = 0;
        end
    end

    task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
        @(posedge clk); #2;
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk);
        case (sel)
            2'd0: m_shadow = d;
            2'd1: m_dst = d;
            2'd2: m_cnt = int'(d[15:0]);
            default: begin
                m_ch = d[0]; m_rel = d[1]; m_size = int'(d[3:2]);
                if (d[0]) begin m_te = 0; m_src = m_shadow; m_grp = 0; end
            end
        endcase
        #2 cfg_we = 1'b0;
    endtask

    task automatic setup(input logic [31:0] s, input logic [31:0] d, input int n,
                         input logic [31:0] ctrl);
        rd_log.delete();
        cfg(2'd0, s);
        cfg(2'd1, d);
        cfg(2'd2, 32'(n));
        cfg(2'd3, ctrl);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000 && !done_flag; i++) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic wait_completions(input int target);
        for (int i = 0; i < 3000 && n_done < target; i++) @(posedge clk);
    endtask

    task automatic expect_idle(input int cycles, input string req);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk(!bus_req, req, 32'(bus_req), 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1; glb_en = 1'b1;
        @(negedge clk);
        chk(!done_flag, "R9 reset done_flag", 32'(done_flag), 0);
        chk(!bus_req, "R9 reset bus_req", 32'(bus_req), 0);

        // 4-byte items, rewind on, 8 transfers
        setup(32'h1000, 32'h8000, 8, 32'h0000_000B);
        wait_done();
        chk(rd_log.size() == 8, "R5 transfer count", 32'(rd_log.size()), 8);
        chk(rd_log[4] == 32'h1000, "R4 fifth read rewinds", rd_log[4], 32'h1000);
        chk(rd_log[3] == 32'h100C, "R3 word step", rd_log[3], 32'h100C);

        // 1-byte items, rewind on, 4 transfers (end and rewind together)
        setup(32'h1100, 32'h8100, 4, 32'h0000_0003);
        wait_done();
        chk(rd_log.size() == 4 && rd_log[3] == 32'h1103, "R3 byte step", rd_log[3], 32'h1103);

        // 2-byte items, rewind off, 5 transfers
        setup(32'h2000, 32'h8800, 5, 32'h0000_0005);
        wait_done();
        chk(rd_log[4] == 32'h2008, "R3 no rewind without mode bit", rd_log[4], 32'h2008);
        // count write alone does not restart
        cfg(2'd2, 32'd2);
        expect_idle(6, "R8 count write keeps channel idle");
        chk(done_flag, "R8 done stays set", 32'(done_flag), 1);
        rd_log.delete();
        cfg(2'd3, 32'h0000_0005);
        wait_done();
        chk(rd_log.size() == 2 && rd_log[0] == 32'h2000, "R8 start reloads source",
            rd_log[0], 32'h2000);

        // NMI after the second completion of a group
        setup(32'h3000, 32'h9000, 12, 32'h0000_000B);
        wait_completions(n_done + 2);
        #2 nmi = 1'b1;
        expect_idle(4, "R6 no start under nmi");
        @(posedge clk); #2 nmi = 1'b0;
        wait_done();
        chk(rd_log.size() == 12, "R5 count after nmi", 32'(rd_log.size()), 12);
        chk(rd_log[6] == 32'h3000, "R7 rewind counted from nmi clear", rd_log[6], 32'h3000);
        chk(rd_log[4] == 32'h3010, "R7 addresses kept over nmi", rd_log[4], 32'h3010);

        // standby after the first completion
        setup(32'h4000, 32'h9100, 8, 32'h0000_0007);
        wait_completions(n_done + 1);
        #2 standby = 1'b1;
        @(posedge clk); #2 standby = 1'b0;
        wait_done();
        chk(rd_log[5] == 32'h4000, "R7 rewind counted from standby clear", rd_log[5], 32'h4000);

        // global enable dropped after the third completion
        setup(32'h5000, 32'h9200, 8, 32'h0000_0003);
        wait_completions(n_done + 3);
        #2 glb_en = 1'b0;
        expect_idle(3, "R6 no start with global enable low");
        @(posedge clk); #2 glb_en = 1'b1;
        wait_done();
        chk(rd_log[7] == 32'h5000, "R7 rewind counted from enable clear", rd_log[7], 32'h5000);
        chk(rd_log[6] == 32'h5006, "R7 source kept over enable loss", rd_log[6], 32'h5006);

        finish_run();
    end
endmodule